// File: doc/BRIEF.md
# Row/Column Multiplexed Memory Command Sequencer

This block turns simple memory requests into the command sequence a row/column addressed memory expects. Each request carries an N-bit address, which the block splits into a row half (upper bits) and a column half (lower bits). Both halves are sent over one shared address bus, one after the other, and four active-low command pins tell the memory which half is on the bus and what to do with it.

The block keeps one row open. A request that falls in the open row goes straight out as a single column command, so a stream of accesses to one row issues one column command per clock. A request to another row first spends one NOP cycle closing the old row, then activates the new row, waits a fixed two-cycle NOP gap, and then issues the column command. While such a sequence is running, the ready output is low and the request inputs are ignored.

Top module: `rc_seq_top`

## Requirements
- R1: The address bus carries the upper ADDR_W/2 request bits during an activate and the lower ADDR_W/2 request bits during a column command.
- R2: Pin values {cs_n, ras_n, cas_n, we_n}: idle deselect 1111, NOP 0111, activate 0011, column read 0101, column write 0100.
- R3: After reset the pins show deselect, ready is high and no row is open.
- R4: When no row is open, an accepted request issues an activate in the next cycle, then exactly two NOP cycles, then its column command; ready is low from the activate until the column command is on the pins.
- R5: A request whose row equals the open row issues its column command in the next cycle with ready staying high, so back-to-back hits give one column command per cycle.
- R6: A request to a different row while a row is open issues one NOP (close) cycle, then an activate of the new row, two NOP cycles and the column command.
- R7: The write flag of the request selects a write column command (we_n low); otherwise a read column command is issued.
- R8: Request inputs presented while ready is low have no effect on the commands or addresses that follow.
- R9: With no request, the pins show deselect and the open row is kept, so a later request to it is still a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address, row in upper half |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ADDR_W/2 | Shared row/column address bus |
| req_ready | output | 1 | Request accepted when high with req_valid |

## Verification
On every cycle the assertions check that only legal pin combinations appear, that an activate is always followed by a NOP and preceded by a NOP or deselect, that a column command only appears with a row open, that ready rises only together with a column command, and that the bus is never deselected while busy. Which row is opened, which column and direction each command carries, the exact gap length, the close step on a row change and the immunity to inputs during busy cycles are shown only by the bench, which sweeps every row with several columns and compares each cycle against a model of the open row.

// File: rtl/rc_seq_pkg.sv
package rc_seq_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR
  } rc_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLOSE,
    ST_ACT,
    ST_GAP,
    ST_COL
  } rc_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } rc_pins_t;

  // Pin pattern for each command, order cs_n, ras_n, cas_n, we_n
  function automatic rc_pins_t rc_encode(rc_cmd_e c);
    rc_pins_t p;
    case (c)
      CMD_NOP: p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      CMD_ACT: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
      CMD_RD:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
      CMD_WR:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b0};
      default: p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/rc_addr_split.sv
module rc_addr_split #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [ADDR_W/2-1:0] row,
  output logic [ADDR_W/2-1:0] col
);
  localparam int HALF_W = ADDR_W / 2;

  function automatic logic [HALF_W-1:0] upper_half(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: HALF_W];
  endfunction

  function automatic logic [HALF_W-1:0] lower_half(logic [ADDR_W-1:0] a);
    return a[HALF_W-1:0];
  endfunction

  assign row = upper_half(addr);
  assign col = lower_half(addr);

  initial begin
    if (ADDR_W % 2 != 0) $error("ADDR_W must be even");
  end
endmodule

// File: rtl/rc_cmd_encode.sv
module rc_cmd_encode
  import rc_seq_pkg::*;
(
  input  rc_cmd_e cmd,
  output logic    cs_n,
  output logic    ras_n,
  output logic    cas_n,
  output logic    we_n
);
  rc_pins_t pins;
  assign pins  = rc_encode(cmd);
  assign cs_n  = pins.cs_n;
  assign ras_n = pins.ras_n;
  assign cas_n = pins.cas_n;
  assign we_n  = pins.we_n;
endmodule

// File: rtl/rc_seq_ctrl.sv
module rc_seq_ctrl
  import rc_seq_pkg::*;
#(
  parameter int HALF_W  = 4,
  parameter int ACT_GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [HALF_W-1:0] req_row,
  input  logic [HALF_W-1:0] req_col,
  output rc_cmd_e           cmd,
  output logic [HALF_W-1:0] bus_addr,
  output logic              ready,
  output logic              row_open,
  output logic              accept,
  output logic              hit
);
  localparam int GAP_CW = (ACT_GAP < 2) ? 1 : $clog2(ACT_GAP);
  localparam logic [GAP_CW-1:0] GAP_LAST = GAP_CW'((ACT_GAP > 0) ? ACT_GAP - 1 : 0);

  rc_state_e         state_q, state_d;
  logic              open_q, open_d;
  logic [HALF_W-1:0] open_row_q, open_row_d;
  logic [HALF_W-1:0] pend_row_q, pend_row_d;
  logic [HALF_W-1:0] pend_col_q, pend_col_d;
  logic              pend_wr_q, pend_wr_d;
  logic [GAP_CW-1:0] gap_q, gap_d;

  assign ready    = (state_q == ST_IDLE) || (state_q == ST_COL);
  assign accept   = ready && req_valid;
  assign hit      = open_q && (req_row == open_row_q);
  assign row_open = open_q;

  always_comb begin
    state_d    = state_q;
    open_d     = open_q;
    open_row_d = open_row_q;
    pend_row_d = pend_row_q;
    pend_col_d = pend_col_q;
    pend_wr_d  = pend_wr_q;
    gap_d      = gap_q;
    case (state_q)
      ST_IDLE, ST_COL: begin
        if (accept) begin
          pend_row_d = req_row;
          pend_col_d = req_col;
          pend_wr_d  = req_write;
          if (hit)         state_d = ST_COL;
          else if (open_q) state_d = ST_CLOSE;
          else             state_d = ST_ACT;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_CLOSE: begin
        open_d  = 1'b0;
        state_d = ST_ACT;
      end
      ST_ACT: begin
        open_d     = 1'b1;
        open_row_d = pend_row_q;
        gap_d      = '0;
        state_d    = (ACT_GAP == 0) ? ST_COL : ST_GAP;
      end
      ST_GAP: begin
        if (gap_q == GAP_LAST) state_d = ST_COL;
        else                   gap_d   = gap_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      open_q     <= 1'b0;
      open_row_q <= '0;
      pend_row_q <= '0;
      pend_col_q <= '0;
      pend_wr_q  <= 1'b0;
      gap_q      <= '0;
    end else begin
      state_q    <= state_d;
      open_q     <= open_d;
      open_row_q <= open_row_d;
      pend_row_q <= pend_row_d;
      pend_col_q <= pend_col_d;
      pend_wr_q  <= pend_wr_d;
      gap_q      <= gap_d;
    end
  end

  always_comb begin
    cmd      = CMD_DESEL;
    bus_addr = '0;
    case (state_q)
      ST_CLOSE, ST_GAP: cmd = CMD_NOP;
      ST_ACT: begin
        cmd      = CMD_ACT;
        bus_addr = pend_row_q;
      end
      ST_COL: begin
        cmd      = pend_wr_q ? CMD_WR : CMD_RD;
        bus_addr = pend_col_q;
      end
      default: cmd = CMD_DESEL;
    endcase
  end

  // R5: a hit keeps the sequencer ready in the following cycle
  p_hit_stays_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hit) |=> ready);

  // R6: a miss with a row open makes the following cycle busy
  p_miss_goes_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hit && row_open) |=> !ready);
endmodule

// File: rtl/rc_seq_top.sv
module rc_seq_top
  import rc_seq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int ACT_GAP = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                mem_cs_n,
  output logic                mem_ras_n,
  output logic                mem_cas_n,
  output logic                mem_we_n,
  output logic [ADDR_W/2-1:0] mem_addr,
  output logic                req_ready
);
  localparam int HALF_W = ADDR_W / 2;

  logic [HALF_W-1:0] row_w, col_w;
  rc_cmd_e           cmd_w;
  logic              row_open_w, accept_w, hit_w;

  rc_addr_split #(.ADDR_W(ADDR_W)) u_split (
    .addr (req_addr),
    .row  (row_w),
    .col  (col_w)
  );

  rc_seq_ctrl #(.HALF_W(HALF_W), .ACT_GAP(ACT_GAP)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_row   (row_w),
    .req_col   (col_w),
    .cmd       (cmd_w),
    .bus_addr  (mem_addr),
    .ready     (req_ready),
    .row_open  (row_open_w),
    .accept    (accept_w),
    .hit       (hit_w)
  );

  rc_cmd_encode u_enc (
    .cmd   (cmd_w),
    .cs_n  (mem_cs_n),
    .ras_n (mem_ras_n),
    .cas_n (mem_cas_n),
    .we_n  (mem_we_n)
  );

  // Pin-level event wires for the checks below
  logic is_act, is_nop, is_desel, is_col;
  assign is_act   = !mem_cs_n && !mem_ras_n &&  mem_cas_n && mem_we_n;
  assign is_nop   = !mem_cs_n &&  mem_ras_n &&  mem_cas_n && mem_we_n;
  assign is_desel =  mem_cs_n;
  assign is_col   = !mem_cs_n &&  mem_ras_n && !mem_cas_n;

  // R2: row and column strobes never fall together, activate never writes
  p_legal_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> (is_act || is_nop || is_col));

  // R4: an activate is always followed by a gap NOP
  p_act_then_nop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> is_nop);

  // R4: ready comes back only together with a column command
  p_ready_with_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> is_col);

  // R6: an activate follows a close NOP or an idle deselect
  p_act_after_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> $past(is_nop || is_desel));

  // R5: a column command needs an open row
  p_col_needs_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> row_open_w);

  // R8: while busy the bus is never deselected
  p_busy_selected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !mem_cs_n);

  // R9: an idle cycle with no request leaves the bus deselected
  p_idle_desel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> is_desel);

  // R3: the first cycle after reset is deselected and ready
  p_reset_state_r3: assert property (@(posedge clk)
    !rst_n |=> (is_desel && req_ready && !row_open_w));

  logic unused_w;
  assign unused_w = accept_w ^ hit_w;
endmodule

// File: tb/tb_rc_seq_top.sv
module tb_rc_seq_top;
  localparam int ADDR_W = 8;
  localparam int HW     = ADDR_W / 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic [HW-1:0]     mem_addr;
  logic              req_ready;

  int total = 0;
  int bad   = 0;

  // model of the open row
  bit            m_open = 0;
  logic [HW-1:0] m_row  = '0;

  localparam logic [3:0] P_DES = 4'b1111;
  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_ACT = 4'b0011;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b0100;

  always #10 clk = ~clk;

  rc_seq_top #(.ADDR_W(ADDR_W), .ACT_GAP(2)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .req_ready(req_ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] pins();
    return {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
  endfunction

  // Called just after a falling edge with ready expected high.
  task automatic issue(input logic [ADDR_W-1:0] a, input bit wr, input string tag);
    logic [HW-1:0] row, col;
    logic [3:0]    seq [5];
    int            n;
    row = a[ADDR_W-1 -: HW];
    col = a[HW-1:0];
    check(req_ready == 1'b1, {tag, " ready before request"}, req_ready, 1);
    if (m_open && row == m_row) begin
      seq[0] = wr ? P_WR : P_RD; n = 1;
    end else if (m_open) begin
      seq[0] = P_NOP; seq[1] = P_ACT; seq[2] = P_NOP; seq[3] = P_NOP;
      seq[4] = wr ? P_WR : P_RD; n = 5;
    end else begin
      seq[0] = P_ACT; seq[1] = P_NOP; seq[2] = P_NOP;
      seq[3] = wr ? P_WR : P_RD; n = 4;
    end
    m_open = 1; m_row = row;
    req_valid = 1'b1; req_write = wr; req_addr = a;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(pins() == seq[i], {tag, " R2 pins"}, pins(), seq[i]);
      if (seq[i] == P_ACT)
        check(mem_addr == row, {tag, " R1 row on bus"}, mem_addr, row);
      if (i == n - 1)
        check(mem_addr == col, {tag, " R1 column on bus"}, mem_addr, col);
      check(req_ready == (i == n - 1), {tag, " R4 ready"}, req_ready, (i == n - 1));
      if (i == n - 1) begin
        req_valid = 1'b0;
      end else begin
        // R8: garbage while busy must be ignored
        req_valid = 1'b1; req_write = ~wr; req_addr = ~a;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(pins() == P_DES, "R9 idle deselect", pins(), P_DES);
      check(req_ready == 1'b1, "R9 idle ready", req_ready, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 reset state
    check(pins() == P_DES, "R3 reset pins", pins(), P_DES);
    check(req_ready == 1'b1, "R3 reset ready", req_ready, 1);
    // R4 first access opens a row
    issue(8'h12, 1'b0, "R4 first");
    // R5 back-to-back hits, R7 direction
    issue(8'h1F, 1'b1, "R5 hit write R7");
    issue(8'h10, 1'b0, "R5 hit read R7");
    // R9 idle keeps the row open
    idle(3);
    issue(8'h13, 1'b1, "R9 hit after idle");
    // R6 row change
    issue(8'h2A, 1'b0, "R6 miss");
    issue(8'h2B, 1'b1, "R6 hit after miss");
    // sweep every row with several columns, R8 garbage during busy
    for (int r = 0; r < 16; r++) begin
      for (int c = 0; c < 16; c += 5) begin
        issue(8'((r << 4) | c), bit'((c ^ r) & 1), "R6 R8 sweep");
      end
      if (r % 4 == 3) idle(2);
    end
    issue(8'h00, 1'b1, "R6 back to row 0");
    idle(1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule